// File: doc/BRIEF.md
# Dropped Frame Statistics Register

This block keeps two drop statistics for a receive path. One counts frames thrown away because the host had no free receive descriptor. The other counts frames lost to a FIFO overflow. Both counters live in one 32-bit read-only word. Each counter has its own sticky bit that records that the counter has wrapped past its maximum.

The drop-detection logic pulses `desc_drop` or `fifo_drop` for one cycle for each lost frame. The register-access logic pulses `rd_stb` in the cycle it samples `stat_word`. That read returns the value the counters held before the read. It also clears both counters and both sticky bits, starting with the following cycle. No event is lost when a drop pulse arrives in the same cycle as a read. That drop becomes the first count after the clear.

The reset input is asynchronous and active-low. Its release is synchronised to the clock inside the block.

Top module: `drop_stat_reg`

## Requirements
- R1: While reset is asserted, and after it is released with no other activity, `stat_word` reads 0x00000000.
- R2: Bits 15:0 hold the descriptor-drop count, which rises by one for each cycle that `desc_drop` is high.
- R3: Bits 27:17 hold an 11-bit FIFO-drop count, which rises by one for each cycle that `fifo_drop` is high.
- R4: A descriptor-drop pulse while bits 15:0 hold 0xFFFF makes that field 0 and sets bit 16.
- R5: A FIFO-drop pulse while bits 27:17 hold 0x7FF makes that field 0 and sets bit 28.
- R6: Once bit 16 or bit 28 is set, it stays set through further counting until a read.
- R7: Bits 31:29 always read as 0.
- R8: In the cycle `rd_stb` is high, `stat_word` still shows the value from before the read. From the next cycle, both counts and both sticky bits are 0.
- R9: A drop pulse in the same cycle as a read leaves its count at 1 after the clear. The other count is left at 0.
- R10: A drop pulse that wraps its counter in the same cycle as a read leaves that counter's sticky bit set and its count at 1.
- R11: Pulses on both drop inputs in one cycle each advance their own count.
- R12: With no drop pulse and no read, `stat_word` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_drop | input | 1 | One-cycle pulse per frame dropped for lack of a descriptor |
| fifo_drop | input | 1 | One-cycle pulse per frame dropped on FIFO overflow |
| rd_stb | input | 1 | Read strobe; the word is returned and then cleared |
| stat_word | output | 32 | Packed counts and sticky wrap bits |

## Verification
The packed word comes straight from the counter and flag registers. A wrong next-state decision therefore shows up in `stat_word` one clock after the pulse or read that caused it.

A clear that is missed or arrives late shows up in the cycle right after the strobe. A wrap bit that fails to set, or that clears too early, stays hidden until a counter passes its maximum. For this reason, the checks drive each counter through a full wrap, then count past it, then clear it with a read, including a read that coincides with the wrap.

// File: rtl/drop_stat_pkg.sv
package drop_stat_pkg;
  localparam int unsigned WORD_W = 32;

  // Encoding matches {rd_stb, drop} so the command is a direct cast.
  typedef enum logic [1:0] {
    CMD_HOLD    = 2'b00,
    CMD_INC     = 2'b01,
    CMD_CLR     = 2'b10,
    CMD_CLR_INC = 2'b11
  } cnt_cmd_e;
endpackage

// File: rtl/drop_rst_sync.sv
module drop_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/drop_wrap_ctr.sv
module drop_wrap_ctr
  import drop_stat_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cnt_cmd_e     cmd,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         wrap_q, wrap_d;
  logic         at_max;
  logic         en;

  assign at_max = &cnt_q;
  assign en     = (cmd != CMD_HOLD);

  always_comb begin
    cnt_d  = cnt_q;
    wrap_d = wrap_q;
    unique case (cmd)
      CMD_HOLD: begin
        cnt_d  = cnt_q;
        wrap_d = wrap_q;
      end
      CMD_INC: begin
        cnt_d  = cnt_q + ONE;
        wrap_d = wrap_q | at_max;
      end
      CMD_CLR: begin
        cnt_d  = '0;
        wrap_d = 1'b0;
      end
      CMD_CLR_INC: begin
        cnt_d  = ONE;
        wrap_d = at_max;
      end
      default: begin
        cnt_d  = cnt_q;
        wrap_d = wrap_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else if (en) begin
      cnt_q  <= cnt_d;
      wrap_q <= wrap_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_INC && !at_max) |=> (cnt_o == $past(cnt_o) + ONE));

  // R4
  wrap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_INC && at_max) |=> (cnt_o == '0 && wrap_o));

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_o && cmd != CMD_CLR && cmd != CMD_CLR_INC) |=> wrap_o);

  // R8
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_CLR) |=> (cnt_o == '0 && !wrap_o));

  // R9
  rd_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_CLR_INC) |=> (cnt_o == ONE && wrap_o == $past(at_max)));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_HOLD) |=> ($stable(cnt_o) && $stable(wrap_o)));
endmodule

// File: rtl/drop_stat_reg.sv
module drop_stat_reg
  import drop_stat_pkg::*;
#(
  parameter int unsigned DESC_W = 16,
  parameter int unsigned FIFO_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_drop,
  input  logic              fifo_drop,
  input  logic              rd_stb,
  output logic [WORD_W-1:0] stat_word
);
  localparam int unsigned DESC_FLAG = DESC_W;
  localparam int unsigned FIFO_LSB  = DESC_W + 1;
  localparam int unsigned FIFO_FLAG = FIFO_LSB + FIFO_W;
  localparam int unsigned USED_W    = FIFO_FLAG + 1;

  logic              rst_sync_n;
  logic [DESC_W-1:0] desc_cnt;
  logic [FIFO_W-1:0] fifo_cnt;
  logic              desc_wrap, fifo_wrap;
  cnt_cmd_e          desc_cmd, fifo_cmd;

  drop_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign desc_cmd = cnt_cmd_e'({rd_stb, desc_drop});
  assign fifo_cmd = cnt_cmd_e'({rd_stb, fifo_drop});

  drop_wrap_ctr #(.W(DESC_W)) u_desc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cmd    (desc_cmd),
    .cnt_o  (desc_cnt),
    .wrap_o (desc_wrap)
  );

  drop_wrap_ctr #(.W(FIFO_W)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cmd    (fifo_cmd),
    .cnt_o  (fifo_cnt),
    .wrap_o (fifo_wrap)
  );

  generate
    if (USED_W < WORD_W) begin : g_pad
      assign stat_word = {{(WORD_W-USED_W){1'b0}}, fifo_wrap, fifo_cnt, desc_wrap, desc_cnt};
    end else begin : g_full
      assign stat_word = {fifo_wrap, fifo_cnt, desc_wrap, desc_cnt};
    end
  endgenerate

  // R8
  clr_word_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_stb && !desc_drop && !fifo_drop) |=> (stat_word == '0));

  // R11
  both_inc_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!rd_stb && desc_drop && fifo_drop && !(&desc_cnt) && !(&fifo_cnt))
      |=> (stat_word[DESC_W-1:0] == $past(stat_word[DESC_W-1:0]) + 1'b1 &&
           stat_word[FIFO_FLAG-1:FIFO_LSB] == $past(stat_word[FIFO_FLAG-1:FIFO_LSB]) + 1'b1));

  // R5
  fifo_wrap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!rd_stb && fifo_drop && (&fifo_cnt)) |=> stat_word[FIFO_FLAG]);
endmodule

// File: tb/sim_drop_stat_reg.sv
`timescale 1ns/1ps
module sim_drop_stat_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        desc_drop = 1'b0;
  logic        fifo_drop = 1'b0;
  logic        rd_stb = 1'b0;
  logic [31:0] stat_word;
  int          tests = 0;
  int          fails = 0;

  always #4 clk = ~clk;

  drop_stat_reg u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .desc_drop (desc_drop),
    .fifo_drop (fifo_drop),
    .rd_stb    (rd_stb),
    .stat_word (stat_word)
  );

  // {desc_drop, fifo_drop, rd_stb, expected word after the edge}
  localparam logic [34:0] VEC [10] = '{
    {3'b100, 32'h0000_0001},   // R2
    {3'b110, 32'h0002_0002},   // R11
    {3'b010, 32'h0004_0002},   // R3
    {3'b000, 32'h0004_0002},   // R12
    {3'b001, 32'h0000_0000},   // R8
    {3'b110, 32'h0002_0001},   // R11
    {3'b011, 32'h0002_0000},   // R9
    {3'b000, 32'h0002_0000},   // R12
    {3'b100, 32'h0002_0001},   // R2
    {3'b001, 32'h0000_0000}    // R8
  };

  task automatic check(input string req, input logic [31:0] exp);
    tests++;
    if (stat_word !== exp) begin
      fails++;
      $display("FAIL %s: stat_word=%h expected=%h", req, stat_word, exp);
    end
  endtask

  task automatic step(input logic d, input logic f, input logic r);
    @(negedge clk);
    desc_drop = d; fifo_drop = f; rd_stb = r;
    @(negedge clk);
    desc_drop = 1'b0; fifo_drop = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic burst_desc(input int n);
    @(negedge clk);
    desc_drop = 1'b1;
    repeat (n) @(negedge clk);
    desc_drop = 1'b0;
  endtask

  task automatic burst_fifo(input int n);
    @(negedge clk);
    fifo_drop = 1'b1;
    repeat (n) @(negedge clk);
    fifo_drop = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", 32'h0);

    for (int i = 0; i < 10; i++) begin
      step(VEC[i][34], VEC[i][33], VEC[i][32]);
      check($sformatf("vector %0d", i), VEC[i][31:0]);
    end

    // R4 / R6 / R8: descriptor counter full wrap
    burst_desc(65535);
    check("R2", 32'h0000_FFFF);
    step(1'b1, 1'b0, 1'b0);
    check("R4", 32'h0001_0000);
    step(1'b1, 1'b1, 1'b0);
    check("R6", 32'h0003_0001);
    @(negedge clk);
    rd_stb = 1'b1;
    #1 check("R8 pre-clear value", 32'h0003_0001);
    @(negedge clk);
    rd_stb = 1'b0;
    check("R8 cleared", 32'h0);

    // R5 / R7: FIFO counter full wrap
    burst_fifo(2047);
    check("R3", 32'h0FFE_0000);
    step(1'b0, 1'b1, 1'b0);
    check("R5", 32'h1000_0000);
    check("R7", stat_word & 32'h1FFF_FFFF);
    step(1'b0, 1'b0, 1'b1);
    check("R8", 32'h0);

    // R10: wrap coincides with read
    burst_fifo(2047);
    step(1'b0, 1'b1, 1'b1);
    check("R10", 32'h1002_0000);
    step(1'b0, 1'b0, 1'b1);
    check("R8", 32'h0);

    // R1: asynchronous reset mid-count
    step(1'b1, 1'b1, 1'b0);
    check("R11", 32'h0002_0001);
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1 async", 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 32'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule